// File: doc/BRIEF.md
# Eight-Function 16-Bit ALU

This block is the combinational arithmetic and logic unit of a small 16-bit processor datapath. A 3-bit function select picks one of eight operations. The unit applies that operation to two 16-bit operands and returns a 16-bit result. The register file supplies the operands from the second and third register fields of the instruction. The result is written back to the first register field. The unit has no clock, no state and no flags.

The selected operation reaches the result with zero latency: a change on any input is visible on the result within the same cycle. Arithmetic wraps to 16 bits. The less-than compare treats both operands as signed. A single shift operation moves left or right depending on the sign of the second operand.

Top module: `octfn_alu`

## Requirements
- R1: With `fn_sel` = 0, `result` equals `opnd_a + opnd_b` modulo 2^16.
- R2: With `fn_sel` = 1, `result` equals `opnd_a - opnd_b` modulo 2^16.
- R3: With `fn_sel` = 2, `result` equals the low 16 bits of the unsigned product `opnd_a * opnd_b`.
- R4: With `fn_sel` = 3, `result` is 1 when `opnd_a` is less than `opnd_b` as signed two's-complement numbers, and 0 otherwise. Bits 15..1 are always 0.
- R5: With `fn_sel` = 4, `result` is the bitwise AND of the operands.
- R6: With `fn_sel` = 5, `result` is the bitwise OR of the operands.
- R7: With `fn_sel` = 6, `result` is the bitwise XOR of the operands.
- R8: With `fn_sel` = 7 and `opnd_b` between 0 and 15, `result` is `opnd_a` shifted left by `opnd_b` bits, with zeros filling the vacated bits.
- R9: With `fn_sel` = 7 and `opnd_b` between -15 and -1 as a signed value, `result` is `opnd_a` shifted right logically by the magnitude of `opnd_b`, with zeros filling from bit 15.
- R10: With `fn_sel` = 7, a shift magnitude of 16 or more in either direction gives 0. This includes `opnd_b` = 0x8000.
- R11: The result is purely combinational. It settles within the same cycle that the inputs change, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 3 | Operation code, taken from the low bits of the opcode |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand; read as a signed shift count for the shift operation |
| result | output | 16 | Operation result |

## Verification
Every result is due zero cycles after its stimulus, because no register sits between the inputs and the result. The bench applies each stimulus one nanosecond after a rising clock edge. It records the expected value in the scoreboard at that moment. The monitor pops and compares on the following falling edge, half a period later, so that every sample is taken after the combinational path has settled and before the next stimulus. Shift counts of exactly 15, 16, -15, -16 and 0x8000 are driven to pin the edges between shifting and zeroing.

// File: rtl/octfn_alu_pkg.sv
package octfn_alu_pkg;

    localparam int ALU_W = 16;
    localparam int FN_W  = 3;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_MUL = 3'd2,
        FN_SLT = 3'd3,
        FN_AND = 3'd4,
        FN_OR  = 3'd5,
        FN_XOR = 3'd6,
        FN_SHF = 3'd7
    } alu_fn_e;

endpackage

// File: rtl/octfn_alu_arith.sv
// Arithmetic unit: wrapping sum, difference, truncated product and a signed compare.
module octfn_alu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic [W-1:0] prod,
    output logic [W-1:0] lt
);
    always_comb begin
        sum  = a + b;
        diff = a - b;
        prod = a * b;
        lt   = '0;
        lt[0] = ($signed(a) < $signed(b));
    end
endmodule

// File: rtl/octfn_alu_logic.sv
// Bitwise unit: the three two-input gate functions.
module octfn_alu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o
);
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        xor_o = a ^ b;
    end
endmodule

// File: rtl/octfn_alu_shift.sv
// Signed-count shifter: positive count moves left, negative moves right (logical).
module octfn_alu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] y
);
    localparam int SH_W = $clog2(W);
    localparam logic [W-1:0] LIMIT = W'(W);

    logic         go_right;
    logic [W-1:0] mag;
    logic         too_far;
    logic [W-1:0] moved;

    always_comb begin
        go_right = cnt[W-1];
        mag      = go_right ? (~cnt + 1'b1) : cnt;
        too_far  = (mag >= LIMIT);
        moved    = go_right ? (a >> mag[SH_W-1:0]) : (a << mag[SH_W-1:0]);
        y        = too_far ? '0 : moved;
    end
endmodule

// File: rtl/octfn_alu.sv
// Top: three function units feeding one select.
module octfn_alu
    import octfn_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [FN_W-1:0] fn_sel,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    output logic [W-1:0]    result
);
    logic [W-1:0] sum_w, diff_w, prod_w, lt_w;
    logic [W-1:0] and_w, or_w, xor_w, shf_w;
    alu_fn_e      fn;

    octfn_alu_arith #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b),
        .sum(sum_w), .diff(diff_w), .prod(prod_w), .lt(lt_w)
    );

    octfn_alu_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
    );

    octfn_alu_shift #(.W(W)) u_shift (
        .a(opnd_a), .cnt(opnd_b), .y(shf_w)
    );

    always_comb begin
        fn = alu_fn_e'(fn_sel);
        unique case (fn)
            FN_ADD: result = sum_w;
            FN_SUB: result = diff_w;
            FN_MUL: result = prod_w;
            FN_SLT: result = lt_w;
            FN_AND: result = and_w;
            FN_OR:  result = or_w;
            FN_XOR: result = xor_w;
            FN_SHF: result = shf_w;
        endcase
    end
endmodule

// File: rtl/octfn_alu_chk.sv
// Property checker attached to the ALU top.
module octfn_alu_chk #(
    parameter int W = 16
) (
    input logic [2:0]   fn_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result
);
    always_comb begin
        if (fn_sel == 3'd0) begin
            // R1
            add_inverse_chk: assert (W'(result - opnd_b) == opnd_a) else $error("add inverse broken");
        end
        if (fn_sel == 3'd1) begin
            // R2
            sub_inverse_chk: assert (W'(result + opnd_b) == opnd_a) else $error("sub inverse broken");
        end
        if (fn_sel == 3'd2 && opnd_b == W'(1)) begin
            // R3
            mul_unit_chk: assert (result == opnd_a) else $error("multiply by one broken");
        end
        if (fn_sel == 3'd3) begin
            // R4
            slt_bool_chk: assert (result[W-1:1] == '0) else $error("compare not boolean");
        end
        if (fn_sel == 3'd4) begin
            // R5
            and_subset_chk: assert ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0) else $error("and leaks bits");
        end
        if (fn_sel == 3'd5) begin
            // R6
            or_cover_chk: assert ((opnd_a & ~result) == '0 && (opnd_b & ~result) == '0) else $error("or drops bits");
        end
        if (fn_sel == 3'd6) begin
            // R7
            xor_inverse_chk: assert ((result ^ opnd_b) == opnd_a) else $error("xor inverse broken");
        end
        if (fn_sel == 3'd7 && opnd_b == '0) begin
            // R8
            shf_zero_chk: assert (result == opnd_a) else $error("zero shift altered value");
        end
        if (fn_sel == 3'd7 && ($signed(opnd_b) >= W) ) begin
            // R10
            shf_far_left_chk: assert (result == '0) else $error("far left shift not zero");
        end
        if (fn_sel == 3'd7 && ($signed(opnd_b) <= -W)) begin
            // R10
            shf_far_right_chk: assert (result == '0) else $error("far right shift not zero");
        end
    end
endmodule

bind octfn_alu octfn_alu_chk #(.W(W)) u_octfn_alu_chk (
    .fn_sel(fn_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
);

// File: tb/octfn_alu_bench.sv
module octfn_alu_bench;
    logic        clk = 1'b0;
    logic [2:0]  fn_sel = 3'd0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    octfn_alu u_octfn_alu (
        .fn_sel(fn_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
    );

    // Reference model built from the requirement text.
    function automatic logic [15:0] model(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] wide;
        int          n;
        logic [15:0] v;
        case (f)
            3'd0: begin wide = {16'h0, a} + {16'h0, b}; return wide[15:0]; end
            3'd1: begin wide = {16'h0, a} + {16'h0, ~b} + 32'd1; return wide[15:0]; end
            3'd2: begin wide = a * b; return wide[15:0]; end
            3'd3: return (int'($signed(a)) < int'($signed(b))) ? 16'd1 : 16'd0;
            3'd4: return a & b;
            3'd5: return a | b;
            3'd6: return a ^ b;
            default: begin
                n = int'($signed(b));
                v = a;
                if (n >= 16 || n <= -16) return 16'h0;
                for (int i = 0; i < (n < 0 ? -n : n); i++)
                    v = (n < 0) ? {1'b0, v[15:1]} : {v[14:0], 1'b0};
                return v;
            end
        endcase
    endfunction

    task automatic drive(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        fn_sel = f;
        opnd_a = a;
        opnd_b = b;
        it.exp = model(f, a, b);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: result is due in the same cycle; sample at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (result !== it.exp) begin
                    fails++;
                    $display("FAIL %s: result=%h expected=%h (fn=%0d a=%h b=%h)",
                             it.tag, result, it.exp, fn_sel, opnd_a, opnd_b);
                end
            end
        end
    end

    initial begin
        // idle state: all-zero inputs give zero (R1)
        drive(3'd0, 16'h0000, 16'h0000, "R1 idle");
        drive(3'd0, 16'h1234, 16'h4321, "R1");
        drive(3'd0, 16'hFFFF, 16'h0002, "R1 wrap");
        drive(3'd1, 16'h5000, 16'h1001, "R2");
        drive(3'd1, 16'h0000, 16'h0001, "R2 wrap");
        drive(3'd2, 16'h0123, 16'h0010, "R3");
        drive(3'd2, 16'hFFFF, 16'hFFFF, "R3 truncate");
        drive(3'd2, 16'h1234, 16'h0000, "R3 zero");
        drive(3'd3, 16'hFFFF, 16'h0001, "R4 neg<pos");
        drive(3'd3, 16'h0001, 16'hFFFF, "R4 pos>neg");
        drive(3'd3, 16'h0007, 16'h0007, "R4 equal");
        drive(3'd3, 16'h8000, 16'h7FFF, "R4 extremes");
        drive(3'd4, 16'hF0F0, 16'h3C3C, "R5");
        drive(3'd5, 16'hF0F0, 16'h0F01, "R6");
        drive(3'd6, 16'hAAAA, 16'hFF00, "R7");
        drive(3'd7, 16'h8001, 16'h0001, "R8 by 1");
        drive(3'd7, 16'h0001, 16'h000F, "R8 by 15");
        drive(3'd7, 16'hBEEF, 16'h0000, "R8 by 0");
        drive(3'd7, 16'h8001, 16'hFFFF, "R9 by -1");
        drive(3'd7, 16'h8000, 16'hFFF1, "R9 by -15");
        drive(3'd7, 16'hFFFF, 16'h0010, "R10 left 16");
        drive(3'd7, 16'hFFFF, 16'hFFF0, "R10 right 16");
        drive(3'd7, 16'hFFFF, 16'h8000, "R10 min count");
        drive(3'd7, 16'hFFFF, 16'h0100, "R10 left 256");
        // back-to-back changes every cycle, same-cycle result (R11)
        for (int k = 0; k < 8; k++)
            drive(3'(k), 16'h1357 + 16'(k * 16'h0111), 16'h0003 + 16'(k), "R11");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule